// File: doc/BRIEF.md
# Serial Window Pattern Detector

The detector samples a one-bit serial stream into a short chain of flip-flops and raises a flag whenever the chain holds a fixed bit pattern. Each enabled rising clock edge shifts a new sample into the first stage and moves every other stage one place toward the last. The stage contents are brought out as parallel taps. The flag is decoded from those taps with combinational logic only, so it follows the window in the same cycle. No sequence state machine is involved, so overlapping occurrences are each flagged.

The pattern and the window length are fixed at elaboration through parameters. The default is a four-stage window looking for `1001`. The pattern literal is written in arrival order: its most significant bit is the sample that arrived first. A low sample-enable freezes the window. The flag then keeps showing the frozen contents.

Top module: `swpd_top`

## Requirements
- R1: While rst_ni is low, every tap reads 0 and match_o is low (the pattern is not all zeros). This holds after reset is released until the next enabled edge.
- R2: On a rising edge with en_i high, taps_o[0] (the newest stage) takes the value of din_i.
- R3: On a rising edge with en_i high, taps_o[k] takes the previous value of taps_o[k-1] for every k from 1 to WIDTH-1. The old taps_o[WIDTH-1] is dropped.
- R4: On a rising edge with en_i low, every tap keeps its value, whatever din_i is.
- R5: match_o is high in exactly the cycles where taps_o equals PATTERN, with no added register delay.
- R6: Overlapping occurrences are each detected. With the default pattern, the enabled stream 1,0,0,1,0,0,1 raises match_o after the 4th and after the 7th sample.
- R7: PATTERN bit WIDTH-1 is compared with the oldest sample and bit 0 with the newest. With PATTERN=1100, the stream 1,1,0,0 matches and the stream 0,0,1,1 does not.
- R8: While en_i is low, match_o keeps the value it had for the held window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Sample enable; when low the window holds |
| din_i | input | 1 | Serial data input |
| taps_o | output | WIDTH | Window stages, bit 0 newest, bit WIDTH-1 oldest |
| match_o | output | 1 | High while the window equals PATTERN |

## Verification
Two cases are hard to reach from the ports.

The first is a second match that reuses the trailing bit of the previous match. The stimulus table drives 1001001 without a break. It checks that match_o falls for exactly two samples and rises again.

The second is bit-order reversal. The symmetric default pattern cannot expose it. A second instance with an asymmetric pattern therefore sees the same stream. The stream contains 0011 before 1100, so only a correctly ordered compare fires on the later window.

// File: rtl/swpd_pkg.sv
package swpd_pkg;
  localparam int unsigned DEF_WIDTH = 4;
  localparam logic [DEF_WIDTH-1:0] DEF_PATTERN = 4'b1001;
endpackage

// File: rtl/swpd_chain.sv
module swpd_chain #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             din_i,
  output logic [WIDTH-1:0] taps_o
);
  logic [WIDTH-1:0] stage_d;

  assign stage_d[0] = din_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    if (k > 0) begin : g_link
      assign stage_d[k] = taps_o[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   taps_o[k] <= 1'b0;
      else if (en_i) taps_o[k] <= stage_d[k];
    end
  end

  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> taps_o[0] == $past(din_i)); // R2
  AST_SHIFT_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> taps_o[WIDTH-1:1] == $past(taps_o[WIDTH-2:0])); // R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(taps_o)); // R4
endmodule

// File: rtl/swpd_match.sv
module swpd_match #(
  parameter int unsigned      WIDTH   = 4,
  parameter logic [WIDTH-1:0] PATTERN = '0
) (
  input  logic [WIDTH-1:0] taps_i,
  output logic             match_o
);
  logic [WIDTH-1:0] bit_eq;

  // bit k of PATTERN lines up with tap k: MSB oldest, LSB newest
  for (genvar k = 0; k < WIDTH; k++) begin : g_cmp
    assign bit_eq[k] = ~(taps_i[k] ^ PATTERN[k]);
  end

  assign match_o = &bit_eq;
endmodule

// File: rtl/swpd_top.sv
module swpd_top #(
  parameter int unsigned      WIDTH   = swpd_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] PATTERN = swpd_pkg::DEF_PATTERN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             din_i,
  output logic [WIDTH-1:0] taps_o,
  output logic             match_o
);
  swpd_chain #(.WIDTH(WIDTH)) chain_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .din_i  (din_i),
    .taps_o (taps_o)
  );

  swpd_match #(.WIDTH(WIDTH), .PATTERN(PATTERN)) match_i (
    .taps_i  (taps_o),
    .match_o (match_o)
  );

  AST_MATCH_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> taps_o == PATTERN); // R5
  AST_MATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> match_o == $past(match_o)); // R8
endmodule

// File: tb/swpd_top_tb_top.sv
module swpd_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       din = 1'b0;
  logic [3:0] taps, taps_a;
  logic       match, match_a;
  int         n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  swpd_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .din_i(din),
    .taps_o(taps), .match_o(match)
  );

  swpd_top #(.WIDTH(4), .PATTERN(4'b1100)) dut_asym_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .din_i(din),
    .taps_o(taps_a), .match_o(match_a)
  );

  // {en, din, expected taps[3:0], expected match}
  localparam int NV = 12;
  localparam logic [6:0] VEC [NV] = '{
    7'b11_0001_0, 7'b10_0010_0, 7'b10_0100_0, 7'b11_1001_1,
    7'b10_0010_0, 7'b10_0100_0, 7'b11_1001_1, 7'b00_1001_1,
    7'b01_1001_1, 7'b11_0011_0, 7'b10_0110_0, 7'b11_1101_0
  };

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic e, logic d);
    @(negedge clk);
    en = e; din = d;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #22;
    check("R1 reset taps/match", {taps, match}, 5'b0000_0);
    check("R1 reset asym", {taps_a, match_a}, 5'b0000_0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b1);
    check("R1 cleared after release", {taps, match}, 5'b0000_0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5]);
      // R2 R3 R4 R5 R6 R8: taps and match follow the table
      check($sformatf("R5 vec %0d", i), {taps, match}, VEC[i][4:0]);
      // R7: the 0011 window must not match 1100
      check($sformatf("R7 asym vec %0d", i), {taps_a, match_a}, {VEC[i][4:1], 1'b0});
    end

    // R7 order: 1,1,0,0 after window 1101
    step(1'b1, 1'b1);
    check("R7 step1", {taps_a, match_a}, 5'b1011_0);
    step(1'b1, 1'b1);
    check("R7 step2", {taps_a, match_a}, 5'b0111_0);
    step(1'b1, 1'b0);
    check("R7 step3", {taps_a, match_a}, 5'b1110_0);
    step(1'b1, 1'b0);
    check("R7 asym match", {taps_a, match_a}, 5'b1100_1);
    check("R5 default no match on 1100", {taps, match}, 5'b1100_0);

    // R4/R8 hold with match high on asym instance
    step(1'b0, 1'b1);
    check("R8 hold asym match", {taps_a, match_a}, 5'b1100_1);

    // R1 mid-run asynchronous reset
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {taps, match}, 5'b0000_0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b1);
    check("R2 first after reset", {taps, match}, 5'b0001_0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule